// File: doc/BRIEF.md
# Multi-CPU Level Interrupt Controller

This block collects a parameterised set of level-held interrupt sources and delivers them to up to four CPUs, with one IRQ line per CPU. Software on any CPU reaches it over a simple register bus. Each access carries the identity of the CPU making it and a window select. The shared window holds the global enables, a control word for each source that names the CPUs it is routed to, and a read-only word giving the source count. The private window of each CPU holds that CPU's mask and its acknowledge register.

Enables and masks have no read-modify-write bitmaps. Software writes a source index to a set register or a clear register, so two CPUs can never undo each other's changes. One source index is set aside for a private per-CPU timer. Each CPU has its own timer line for it, and only that CPU's mask gates it. The two lowest indices carry the summaries from the doorbell unit. They need no special logic, because the lowest eligible index always wins.

An acknowledge read returns the winning source for the reading CPU, or a sentinel when nothing is pending. Sources are level-held, so the read has no side effect.

Top module: `mic_top`

## Requirements
- R1: After reset every IRQ output is low, all sources are globally disabled, masked on every CPU and routed nowhere, and the shared control word at offset 0x00 reads the source count in bits [11:2].
- R2: In the shared window, writing a source index to 0x30 sets its global enable and writing it to 0x34 clears it.
- R3: In a CPU's private window, writing a source index to 0x48 masks that source for the accessing CPU only, and writing it to 0x4C unmasks it for that CPU only.
- R4: Each source n has a routing word at shared offset 0x100+4*n. Bit c of its low bits routes the source to CPU c, and the word reads back with the FIQ bits [11:8] as zero.
- R5: The IRQ output of CPU c is high one cycle after an ordinary source is at level 1, globally enabled, routed to c and unmasked on c, and low one cycle after no source is eligible.
- R6: A read of private offset 0x44 returns, in bits [9:0], the lowest-numbered source eligible for the reading CPU, or 1023 when none is.
- R7: An acknowledge read has no side effect: a repeated read returns the same value while the inputs are unchanged.
- R8: Source 5 is the private timer. For CPU c it is eligible when timer input c is high and source 5 is unmasked on c. Its global enable, its routing word and its shared level input have no effect.
- R9: Writes to the enable or mask registers with an index at or above the source count change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_level | input | NUM_SRC | Level inputs of the shared sources |
| timer_irq | input | NUM_CPUS | Private timer line of each CPU |
| bus_cpu | input | CPU_W | Index of the CPU making the access |
| bus_private | input | 1 | 1 selects the private window, 0 the shared window |
| bus_addr | input | 12 | Byte offset inside the window |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | High for one cycle after a read is sampled |
| irq_out | output | NUM_CPUS | IRQ line per CPU |

## Verification
A write sampled on a clock edge updates the enable, mask or routing state on that edge. A read issued in the following cycle sees the new state. Read data arrives one edge after the read strobe is sampled. An IRQ output follows the state or a level input one edge later. The bench drives on falling edges and compares read data on the falling edge right after the sampling edge. It checks IRQ lines one full cycle after the write or level change that affects them.

// File: rtl/mic_pkg.sv
package mic_pkg;
  localparam int ADDR_W = 12;
  localparam int ACK_W  = 10;

  localparam logic [ADDR_W-1:0] OFF_INFO      = 12'h000;
  localparam logic [ADDR_W-1:0] OFF_EN_SET    = 12'h030;
  localparam logic [ADDR_W-1:0] OFF_EN_CLR    = 12'h034;
  localparam logic [ADDR_W-1:0] OFF_ACK       = 12'h044;
  localparam logic [ADDR_W-1:0] OFF_MASK_SET  = 12'h048;
  localparam logic [ADDR_W-1:0] OFF_MASK_CLR  = 12'h04C;
  localparam logic [ADDR_W-1:0] OFF_ROUTE_LO  = 12'h100;

  localparam logic [ACK_W-1:0]  ACK_NONE      = 10'd1023;
endpackage

// File: rtl/mic_src_regs.sv
module mic_src_regs #(
  parameter int NUM_SRC  = 32,
  parameter int NUM_CPUS = 4,
  localparam int SRC_W   = $clog2(NUM_SRC)
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              en_set,
  input  logic                              en_clr,
  input  logic [SRC_W-1:0]                  en_idx,
  input  logic                              route_we,
  input  logic [SRC_W-1:0]                  route_idx,
  input  logic [NUM_CPUS-1:0]               route_val,
  output logic [NUM_SRC-1:0]                en_q,
  output logic [NUM_SRC-1:0][NUM_CPUS-1:0]  route_q
);
  logic [NUM_SRC-1:0]               en_d;
  logic [NUM_SRC-1:0][NUM_CPUS-1:0] route_d;

  always_comb begin
    en_d    = en_q;
    route_d = route_q;
    if (en_set) en_d[en_idx] = 1'b1;
    if (en_clr) en_d[en_idx] = 1'b0;
    if (route_we) route_d[route_idx] = route_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= '0;
      route_q <= '0;
    end else begin
      if (en_set || en_clr) en_q <= en_d;
      if (route_we)         route_q <= route_d;
    end
  end

  assert_en_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    en_set |=> en_q[$past(en_idx)]);
  assert_en_clr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    en_clr |=> !en_q[$past(en_idx)]);
endmodule

// File: rtl/mic_cpu_mask.sv
module mic_cpu_mask #(
  parameter int NUM_SRC  = 32,
  parameter int NUM_CPUS = 4,
  localparam int SRC_W   = $clog2(NUM_SRC),
  localparam int CPU_W   = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              msk_set,
  input  logic                              msk_clr,
  input  logic [CPU_W-1:0]                  msk_cpu,
  input  logic [SRC_W-1:0]                  msk_idx,
  output logic [NUM_CPUS-1:0][NUM_SRC-1:0]  mask_q
);
  logic [NUM_CPUS-1:0][NUM_SRC-1:0] mask_d;

  always_comb begin
    mask_d = mask_q;
    if (msk_set) mask_d[msk_cpu][msk_idx] = 1'b1;
    if (msk_clr) mask_d[msk_cpu][msk_idx] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                mask_q <= '1;
    else if (msk_set || msk_clr) mask_q <= mask_d;
  end

  assert_mask_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    msk_set |=> mask_q[$past(msk_cpu)][$past(msk_idx)]);
  assert_mask_clr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    msk_clr |=> !mask_q[$past(msk_cpu)][$past(msk_idx)]);
endmodule

// File: rtl/mic_pick.sv
module mic_pick #(
  parameter int NUM_SRC = 32,
  localparam int SRC_W  = $clog2(NUM_SRC)
) (
  input  logic [NUM_SRC-1:0] elig,
  output logic               found,
  output logic [SRC_W-1:0]   idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int n = NUM_SRC - 1; n >= 0; n--) begin
      if (elig[n]) begin
        found = 1'b1;
        idx   = SRC_W'(n);
      end
    end
  end
endmodule

// File: rtl/mic_top.sv
module mic_top
  import mic_pkg::*;
#(
  parameter int NUM_SRC   = 32,
  parameter int NUM_CPUS  = 4,
  parameter int TIMER_SRC = 5,
  localparam int SRC_W    = $clog2(NUM_SRC),
  localparam int CPU_W    = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_SRC-1:0]   src_level,
  input  logic [NUM_CPUS-1:0]  timer_irq,
  input  logic [CPU_W-1:0]     bus_cpu,
  input  logic                 bus_private,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic                 bus_wr,
  input  logic [31:0]          bus_wdata,
  input  logic                 bus_rd,
  output logic [31:0]          bus_rdata,
  output logic                 bus_rvalid,
  output logic [NUM_CPUS-1:0]  irq_out
);
  logic [ACK_W-1:0]  wr_idx_raw;
  logic              idx_ok;
  logic [SRC_W-1:0]  wr_idx;
  logic [ADDR_W-1:0] route_off;
  logic [ACK_W-1:0]  route_n;
  logic              route_hit;
  logic              en_set, en_clr, msk_set, msk_clr, route_we;

  assign wr_idx_raw = bus_wdata[ACK_W-1:0];
  assign idx_ok     = wr_idx_raw < ACK_W'(NUM_SRC);
  assign wr_idx     = wr_idx_raw[SRC_W-1:0];
  assign route_off  = bus_addr - OFF_ROUTE_LO;
  assign route_n    = route_off[ADDR_W-1:2];
  assign route_hit  = !bus_private && (bus_addr >= OFF_ROUTE_LO) &&
                      (bus_addr[1:0] == 2'b00) && (route_n < ACK_W'(NUM_SRC));

  assign en_set   = bus_wr && !bus_private && bus_addr == OFF_EN_SET && idx_ok;
  assign en_clr   = bus_wr && !bus_private && bus_addr == OFF_EN_CLR && idx_ok;
  assign msk_set  = bus_wr && bus_private && bus_addr == OFF_MASK_SET && idx_ok;
  assign msk_clr  = bus_wr && bus_private && bus_addr == OFF_MASK_CLR && idx_ok;
  assign route_we = bus_wr && route_hit;

  logic [NUM_SRC-1:0]                en_q;
  logic [NUM_SRC-1:0][NUM_CPUS-1:0]  route_q;
  logic [NUM_CPUS-1:0][NUM_SRC-1:0]  mask_q;

  mic_src_regs #(.NUM_SRC(NUM_SRC), .NUM_CPUS(NUM_CPUS)) u_src (
    .clk(clk), .rst_n(rst_n),
    .en_set(en_set), .en_clr(en_clr), .en_idx(wr_idx),
    .route_we(route_we), .route_idx(route_n[SRC_W-1:0]),
    .route_val(bus_wdata[NUM_CPUS-1:0]),
    .en_q(en_q), .route_q(route_q)
  );

  mic_cpu_mask #(.NUM_SRC(NUM_SRC), .NUM_CPUS(NUM_CPUS)) u_mask (
    .clk(clk), .rst_n(rst_n),
    .msk_set(msk_set), .msk_clr(msk_clr), .msk_cpu(bus_cpu), .msk_idx(wr_idx),
    .mask_q(mask_q)
  );

  logic [NUM_CPUS-1:0][NUM_SRC-1:0] elig;
  logic [NUM_CPUS-1:0]              pick_found;
  logic [NUM_CPUS-1:0][SRC_W-1:0]   pick_idx;

  for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cpu
    for (genvar n = 0; n < NUM_SRC; n++) begin : g_src
      if (n == TIMER_SRC) begin : g_timer
        assign elig[c][n] = timer_irq[c] && !mask_q[c][n];
      end else begin : g_shared
        assign elig[c][n] = src_level[n] && en_q[n] && route_q[n][c] && !mask_q[c][n];
      end
    end
    mic_pick #(.NUM_SRC(NUM_SRC)) u_pick (
      .elig(elig[c]), .found(pick_found[c]), .idx(pick_idx[c])
    );

    assert_pick_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
      pick_found[c] |-> elig[c][pick_idx[c]]);
    assert_quiet_when_masked_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (&mask_q[c]) |=> !irq_out[c]);
  end

  logic [NUM_CPUS-1:0] irq_d;
  always_comb begin
    for (int c = 0; c < NUM_CPUS; c++) irq_d[c] = pick_found[c];
  end

  logic [31:0] rdata_d;
  always_comb begin
    rdata_d = '0;
    if (bus_private) begin
      if (bus_addr == OFF_ACK)
        rdata_d[ACK_W-1:0] = pick_found[bus_cpu] ? ACK_W'(pick_idx[bus_cpu]) : ACK_NONE;
    end else if (bus_addr == OFF_INFO) begin
      rdata_d[11:2] = ACK_W'(NUM_SRC);
    end else if (route_hit) begin
      rdata_d[NUM_CPUS-1:0] = route_q[route_n[SRC_W-1:0]];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_out    <= '0;
      bus_rvalid <= 1'b0;
      bus_rdata  <= '0;
    end else begin
      irq_out    <= irq_d;
      bus_rvalid <= bus_rd;
      if (bus_rd) bus_rdata <= rdata_d;
    end
  end

  logic unused_inputs;
  assign unused_inputs = ^{src_level[TIMER_SRC], bus_wdata[31:ACK_W], route_off[1:0]};

  assert_ack_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_private && bus_addr == OFF_ACK && !pick_found[bus_cpu])
      |=> bus_rdata[ACK_W-1:0] == ACK_NONE);
  assert_bad_index_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !idx_ok && !route_hit) |=> ($stable(en_q) && $stable(mask_q)));
endmodule

// File: tb/mic_top_test.sv
`timescale 1ns/1ps
module mic_top_test;
  localparam int NS = 32;
  localparam int NC = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NS-1:0] src_level;
  logic [NC-1:0] timer_irq;
  logic [1:0]    bus_cpu;
  logic          bus_private;
  logic [11:0]   bus_addr;
  logic          bus_wr;
  logic [31:0]   bus_wdata;
  logic          bus_rd;
  logic [31:0]   bus_rdata;
  logic          bus_rvalid;
  logic [NC-1:0] irq_out;

  int checks = 0;
  int errors = 0;
  int    exp_q[$];
  string tag_q[$];

  always #2.5 clk = ~clk;

  mic_top #(.NUM_SRC(NS), .NUM_CPUS(NC), .TIMER_SRC(5)) uut (
    .clk(clk), .rst_n(rst_n), .src_level(src_level), .timer_irq(timer_irq),
    .bus_cpu(bus_cpu), .bus_private(bus_private), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rd(bus_rd),
    .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid), .irq_out(irq_out)
  );

  task automatic wr(input logic pw, input int cpu, input int addr, input int data);
    bus_private = pw; bus_cpu = 2'(cpu); bus_addr = 12'(addr);
    bus_wdata = data; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic pw, input int cpu, input int addr, input int exp, input string tag);
    exp_q.push_back(exp); tag_q.push_back(tag);
    bus_private = pw; bus_cpu = 2'(cpu); bus_addr = 12'(addr); bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic chk_irq(input int cpu, input logic exp, input string tag);
    @(negedge clk);
    checks++;
    if (irq_out[cpu] !== exp) begin
      errors++;
      $display("FAIL %s irq_out[%0d] actual=%b expected=%b", tag, cpu, irq_out[cpu], exp);
    end
  endtask

  always @(negedge clk) begin
    if (bus_rvalid && exp_q.size() > 0) begin
      int e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (bus_rdata !== 32'(e)) begin
        errors++;
        $display("FAIL %s rdata actual=%0d expected=%0d", t, bus_rdata, e);
      end
    end
  end

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    rst_n = 1'b0; src_level = '0; timer_irq = '0; bus_cpu = '0; bus_private = 1'b0;
    bus_addr = '0; bus_wr = 1'b0; bus_wdata = '0; bus_rd = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int c = 0; c < NC; c++) chk_irq(c, 1'b0, "R1");
    rd(1'b0, 0, 'h000, NS << 2, "R1 info");
    rd(1'b1, 0, 'h044, 1023, "R1 ack");

    // R2 R4 R3 R5: source 9 to CPU1
    src_level[9] = 1'b1;
    wr(1'b0, 0, 'h030, 9);
    wr(1'b0, 0, 'h124, 2);
    rd(1'b0, 0, 'h124, 2, "R4 route readback");
    chk_irq(1, 1'b0, "R3 still masked");
    wr(1'b1, 1, 'h04C, 9);
    chk_irq(1, 1'b1, "R5 raise");
    chk_irq(0, 1'b0, "R5 other cpu");
    rd(1'b1, 1, 'h044, 9, "R6 ack");
    rd(1'b1, 1, 'h044, 9, "R7 repeat ack");
    rd(1'b1, 0, 'h044, 1023, "R6 not routed");

    // R6 lowest wins; R3 per-CPU unmask
    src_level[3] = 1'b1;
    wr(1'b0, 0, 'h030, 3);
    wr(1'b0, 0, 'h10C, 6);
    wr(1'b1, 1, 'h04C, 3);
    rd(1'b1, 1, 'h044, 3, "R6 lowest");
    chk_irq(2, 1'b0, "R3 cpu2 masked");
    wr(1'b1, 2, 'h04C, 3);
    chk_irq(2, 1'b1, "R3 cpu2 unmasked");

    // R2 clear enable, R3 mask
    wr(1'b0, 0, 'h034, 3);
    rd(1'b1, 1, 'h044, 9, "R2 clear");
    wr(1'b1, 1, 'h048, 9);
    rd(1'b1, 1, 'h044, 1023, "R3 mask");
    chk_irq(1, 1'b0, "R3 irq drop");

    // R9 out-of-range indices alias nothing
    wr(1'b0, 0, 'h034, 41);
    wr(1'b1, 1, 'h048, 41);
    wr(1'b1, 1, 'h04C, 9);
    rd(1'b1, 1, 'h044, 9, "R9 enable kept");
    wr(1'b1, 1, 'h04C, 35);
    wr(1'b0, 0, 'h034, 9);
    rd(1'b1, 1, 'h044, 1023, "R9 mask kept");
    wr(1'b0, 0, 'h030, 9);

    // R8 private timer
    src_level[5] = 1'b1;
    wr(1'b0, 0, 'h030, 5);
    wr(1'b0, 0, 'h114, 15);
    rd(1'b1, 0, 'h044, 1023, "R8 shared line ignored");
    wr(1'b1, 0, 'h04C, 5);
    rd(1'b1, 0, 'h044, 1023, "R8 no timer line");
    timer_irq[2] = 1'b1;
    wr(1'b1, 2, 'h04C, 5);
    rd(1'b1, 2, 'h044, 5, "R8 timer cpu2");
    wr(1'b0, 0, 'h034, 5);
    rd(1'b1, 2, 'h044, 5, "R8 enable ignored");
    timer_irq[2] = 1'b0;
    rd(1'b1, 2, 'h044, 1023, "R8 timer low");

    // R4 reroute, R5 level drop
    wr(1'b0, 0, 'h124, 1);
    wr(1'b1, 0, 'h04C, 9);
    rd(1'b1, 0, 'h044, 9, "R4 rerouted");
    rd(1'b1, 1, 'h044, 1023, "R4 old cpu");
    chk_irq(0, 1'b1, "R5 cpu0");
    src_level[9] = 1'b0;
    chk_irq(0, 1'b0, "R5 level drop");
    rd(1'b1, 0, 'h044, 1023, "R6 empty");

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      errors++; checks++;
      $display("FAIL readout actual=%0d pending expected=0", exp_q.size());
    end
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule